// File: doc/BRIEF.md
# I/O Port Access Sequencer

This block sits between a processor's execution logic and a 32-bit system bus. It turns a single port read or port write request into one or two bus cycles in an I/O space kept apart from memory. The port number is 16 bits wide, which gives 65,536 byte-wide ports. Adjacent byte ports can be used together as a 16-bit or 32-bit port. The requester takes the port number from one of two sources: an 8-bit immediate, which is zero-extended, or a 16-bit register value. It also supplies the transfer size, the direction and, for writes, the data.

The sequencer works out the dword address and the byte enables. It steers write data onto the correct byte lanes and holds each bus cycle until the bus answers with ready. A multi-byte access that spills past a dword boundary becomes two bus cycles: first the lower dword, then the next one. The read bytes from both cycles are merged, and the port's lowest byte is returned at bit 0. A one-cycle done pulse marks the end of every request.

Top module: `ioPortSeq`

## Requirements
- R1: With `reqUseReg` low the port number is `{8'h00, reqImm}`; with `reqUseReg` high it is `reqReg`, so any port 0 to 65535 can be reached.
- R2: Every bus cycle presents `busAddr` = port number bits [15:2], zero-extended to 30 bits. `busIoSpace` is high and `busWrite` equals the request direction.
- R3: Size code 2'b00 is a byte, 2'b01 a word and 2'b10 (or 2'b11) a dword. The byte enables are the size's lane mask (1, 3 or 4 lanes), shifted left by port bits [1:0]. Bit i of `busBe` is lane i, which is data bits [8i+7:8i].
- R4: An access whose lanes all fall inside one dword takes exactly one bus cycle. This covers any byte, a word at offset 0, 1 or 2, and a dword at offset 0. An access that spills past the dword takes two cycles. The first cycle uses the port's dword and the lanes from the offset upward. The second uses the next dword index (0x3FFF wraps to 0) and the remaining low lanes.
- R5: On a write, byte k of `reqWdata` goes onto the lane of port byte address (port+k). It appears in the bus cycle whose dword holds that address.
- R6: On a read, the byte at port+k is returned in `rdData[8k+7:8k]`, and bytes above the transfer size read as zero.
- R7: While `busValid` is high and `busReady` is low, `busValid`, `busAddr`, `busBe`, `busWdata` and `busWrite` stay unchanged.
- R8: `done` is a one-cycle pulse in the cycle after the clock edge at which the final bus cycle sees `busReady`. `busy` is high from the cycle after acceptance until then. `reqValid` while `busy` is high is ignored and starts no bus cycle.
- R9: After reset `busValid`, `done` and `busy` are low and `rdData` is zero.
- R10: A write request leaves `rdData` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, taken when not busy |
| reqWrite | input | 1 | 1 = port write, 0 = port read |
| reqUseReg | input | 1 | Address source: 1 = register, 0 = immediate |
| reqImm | input | 8 | Immediate port number |
| reqReg | input | 16 | Register port number |
| reqSize | input | 2 | Transfer size code |
| reqWdata | input | 32 | Write data, port byte 0 at bits [7:0] |
| busy | output | 1 | Request in progress |
| done | output | 1 | Request complete pulse |
| rdData | output | 32 | Read result, port byte 0 at bits [7:0] |
| busValid | output | 1 | Bus cycle active |
| busAddr | output | 30 | Dword address |
| busBe | output | 4 | Byte lane enables |
| busWrite | output | 1 | Bus cycle direction |
| busIoSpace | output | 1 | I/O space select (high for all port cycles) |
| busWdata | output | 32 | Lane-steered write data |
| busRdata | input | 32 | Bus read data |
| busReady | input | 1 | Bus cycle completion |

## Verification
The hardest case is a split dword access at the very top of the port space. There the second cycle has to wrap its dword index to zero while the read bytes are still merged across both cycles. The bench first writes a dword at port 0xFFFE, which puts bytes at 0xFFFE, 0xFFFF, 0x0000 and 0x0001. It then reads the same port back and also reads port 0 through the immediate source. The bus model answers after a varying delay and fills unenabled lanes with a filler byte. A request pulsed in the middle of a bus cycle must produce no extra bus cycle.

// File: rtl/ioPortPkg.sv
package ioPortPkg;
  localparam logic [1:0] SIZE_BYTE  = 2'b00;
  localparam logic [1:0] SIZE_WORD  = 2'b01;
  localparam logic [1:0] SIZE_DWORD = 2'b10;

  typedef struct packed {
    logic loadReq;   // capture a new request
    logic capLo;     // store read data of the first of two cycles
    logic phaseHi;   // second bus cycle of a split access
    logic finish;    // final bus cycle completes this edge
  } ctrlStrobe_t;
endpackage

// File: rtl/ioPortDatapath.sv
module ioPortDatapath
  import ioPortPkg::*;
#(
  parameter int PORT_W = 16,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 30
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctrlStrobe_t             strobe,
  input  logic                    reqWrite,
  input  logic                    reqUseReg,
  input  logic [7:0]              reqImm,
  input  logic [PORT_W-1:0]       reqReg,
  input  logic [1:0]              reqSize,
  input  logic [DATA_W-1:0]       reqWdata,
  input  logic [DATA_W-1:0]       busRdata,
  output logic                    needSplit,
  output logic [ADDR_W-1:0]       busAddr,
  output logic [DATA_W/8-1:0]     busBe,
  output logic [DATA_W-1:0]       busWdata,
  output logic                    busWrite,
  output logic [DATA_W-1:0]       rdData
);
  localparam int LANES = DATA_W / 8;
  localparam int OFF_W = $clog2(LANES);
  localparam int IDX_W = PORT_W - OFF_W;

  logic [PORT_W-1:0]   portQ;
  logic [1:0]          sizeQ;
  logic                writeQ;
  logic [DATA_W-1:0]   wdataQ;
  logic [DATA_W-1:0]   rdLoQ;
  logic [DATA_W-1:0]   rdDataQ;

  logic [PORT_W-1:0]   portIn;
  logic [OFF_W-1:0]    offset;
  logic [LANES-1:0]    sizeMask;
  logic [2*LANES-1:0]  laneMask;
  logic [2*DATA_W-1:0] wideWdata;
  logic [2*DATA_W-1:0] mergedRd;
  logic [2*DATA_W-1:0] shiftedRd;
  logic [DATA_W-1:0]   byteMaskBits;
  logic [IDX_W-1:0]    dwIdx;
  logic [IDX_W-1:0]    nextIdx;
  logic [OFF_W+2:0]    bitShift;

  // address source select, immediate is zero-extended
  assign portIn = reqUseReg ? reqReg : {{(PORT_W-8){1'b0}}, reqImm};

  assign offset   = portQ[OFF_W-1:0];
  assign bitShift = {offset, 3'b000};
  assign dwIdx    = portQ[PORT_W-1:OFF_W];
  assign nextIdx  = dwIdx + 1'b1;

  always_comb begin
    unique case (sizeQ)
      SIZE_BYTE: sizeMask = LANES'(1);
      SIZE_WORD: sizeMask = LANES'(3);
      default:   sizeMask = '1;
    endcase
  end

  assign laneMask  = {{LANES{1'b0}}, sizeMask} << offset;
  assign wideWdata = {{DATA_W{1'b0}}, wdataQ} << bitShift;
  assign needSplit = |laneMask[2*LANES-1:LANES];

  assign busAddr  = ADDR_W'(strobe.phaseHi ? nextIdx : dwIdx);
  assign busBe    = strobe.phaseHi ? laneMask[2*LANES-1:LANES] : laneMask[LANES-1:0];
  assign busWdata = strobe.phaseHi ? wideWdata[2*DATA_W-1:DATA_W] : wideWdata[DATA_W-1:0];
  assign busWrite = writeQ;

  generate
    for (genvar ln = 0; ln < LANES; ln++) begin : g_byteMask
      assign byteMaskBits[8*ln +: 8] = {8{sizeMask[ln]}};
    end
  endgenerate

  assign mergedRd  = strobe.phaseHi ? {busRdata, rdLoQ} : {{DATA_W{1'b0}}, busRdata};
  assign shiftedRd = mergedRd >> bitShift;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      portQ   <= '0;
      sizeQ   <= SIZE_BYTE;
      writeQ  <= 1'b0;
      wdataQ  <= '0;
      rdLoQ   <= '0;
      rdDataQ <= '0;
    end else begin
      if (strobe.loadReq) begin
        portQ  <= portIn;
        sizeQ  <= reqSize;
        writeQ <= reqWrite;
        wdataQ <= reqWdata;
      end
      if (strobe.capLo) rdLoQ <= busRdata;
      if (strobe.finish && !writeQ)
        rdDataQ <= shiftedRd[DATA_W-1:0] & byteMaskBits;
    end
  end

  assign rdData = rdDataQ;

  // R3: a word that fits in one dword always enables exactly two lanes
  p_word_two_lanes_r3: assert property (@(posedge clk) disable iff (!rstN)
    (sizeQ == SIZE_WORD && !needSplit) |-> ($countones(busBe) == 2));

  // R4: the second phase exists only for an access that spills over
  p_hi_needs_split_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.phaseHi |-> needSplit);

  // R10: a completing write never alters the read result
  p_write_keeps_rd_r10: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.finish && writeQ) |=> $stable(rdData));
endmodule

// File: rtl/ioPortCtrl.sv
module ioPortCtrl
  import ioPortPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        busReady,
  input  logic        needSplit,
  output ctrlStrobe_t strobe,
  output logic        busValid,
  output logic        busy,
  output logic        done
);
  typedef enum logic [1:0] {ST_IDLE, ST_LO, ST_HI} seqState_e;

  seqState_e state, stateNext;
  logic      doneQ;

  always_comb begin
    strobe         = '0;
    stateNext      = state;
    strobe.phaseHi = (state == ST_HI);
    unique case (state)
      ST_IDLE: if (reqValid) begin
        strobe.loadReq = 1'b1;
        stateNext      = ST_LO;
      end
      ST_LO: if (busReady) begin
        if (needSplit) begin
          strobe.capLo = 1'b1;
          stateNext    = ST_HI;
        end else begin
          strobe.finish = 1'b1;
          stateNext     = ST_IDLE;
        end
      end
      ST_HI: if (busReady) begin
        strobe.finish = 1'b1;
        stateNext     = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      doneQ <= 1'b0;
    end else begin
      state <= stateNext;
      doneQ <= strobe.finish;
    end
  end

  assign busValid = (state != ST_IDLE);
  assign busy     = (state != ST_IDLE);
  assign done     = doneQ;

  // R8: done lasts one cycle only
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8: done follows a ready seen during an active bus cycle
  p_done_after_ready_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ($past(busReady) && $past(busValid)));

  // R4: the high phase is entered only from the low phase
  p_hi_from_lo_r4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HI && $past(state) != ST_HI) |-> ($past(state) == ST_LO));
endmodule

// File: rtl/ioPortSeq.sv
module ioPortSeq
  import ioPortPkg::*;
#(
  parameter int PORT_W = 16,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 30
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic                reqWrite,
  input  logic                reqUseReg,
  input  logic [7:0]          reqImm,
  input  logic [PORT_W-1:0]   reqReg,
  input  logic [1:0]          reqSize,
  input  logic [DATA_W-1:0]   reqWdata,
  output logic                busy,
  output logic                done,
  output logic [DATA_W-1:0]   rdData,
  output logic                busValid,
  output logic [ADDR_W-1:0]   busAddr,
  output logic [DATA_W/8-1:0] busBe,
  output logic                busWrite,
  output logic                busIoSpace,
  output logic [DATA_W-1:0]   busWdata,
  input  logic [DATA_W-1:0]   busRdata,
  input  logic                busReady
);
  ctrlStrobe_t strobe;
  logic        needSplit;

  ioPortCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .busReady(busReady),
    .needSplit(needSplit), .strobe(strobe), .busValid(busValid),
    .busy(busy), .done(done)
  );

  ioPortDatapath #(.PORT_W(PORT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqWrite(reqWrite),
    .reqUseReg(reqUseReg), .reqImm(reqImm), .reqReg(reqReg), .reqSize(reqSize),
    .reqWdata(reqWdata), .busRdata(busRdata), .needSplit(needSplit),
    .busAddr(busAddr), .busBe(busBe), .busWdata(busWdata), .busWrite(busWrite),
    .rdData(rdData)
  );

  assign busIoSpace = busValid;

  // R7: a pending bus cycle holds everything until ready
  p_hold_until_ready_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busReady) |=> (busValid && $stable(busAddr) && $stable(busBe)
                                 && $stable(busWdata) && $stable(busWrite)));

  // R3: an active cycle always enables at least one lane
  p_lanes_nonzero_r3: assert property (@(posedge clk) disable iff (!rstN)
    busValid |-> (busBe != '0));
endmodule

// File: tb/ioPortSeq_test.sv
module ioPortSeq_test;
  typedef struct packed {
    logic [29:0] addr;
    logic [3:0]  be;
    logic        wr;
    logic [31:0] wdata;
  } cyc_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 0, reqWrite = 0, reqUseReg = 0;
  logic [7:0] reqImm = 0;
  logic [15:0] reqReg = 0;
  logic [1:0] reqSize = 0;
  logic [31:0] reqWdata = 0;
  logic busy, done, busValid, busWrite, busIoSpace;
  logic [31:0] rdData, busWdata;
  logic [29:0] busAddr;
  logic [3:0] busBe;
  logic [31:0] busRdata = 32'hDEADBEEF;
  logic busReady = 1'b0;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [7:0] mem [0:65535];
  cyc_t cycQ[$];
  logic [31:0] resQ[$];
  logic [31:0] lastRead = 32'h0;
  int cycNum = 0;

  always #2.5 clk = ~clk;

  ioPortSeq uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqUseReg(reqUseReg), .reqImm(reqImm), .reqReg(reqReg), .reqSize(reqSize),
    .reqWdata(reqWdata), .busy(busy), .done(done), .rdData(rdData),
    .busValid(busValid), .busAddr(busAddr), .busBe(busBe), .busWrite(busWrite),
    .busIoSpace(busIoSpace), .busWdata(busWdata), .busRdata(busRdata),
    .busReady(busReady)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] laneBits(input logic [3:0] be);
    logic [31:0] m;
    for (int l = 0; l < 4; l++) m[8*l +: 8] = {8{be[l]}};
    return m;
  endfunction

  // bus responder: compares each cycle against the scoreboard, then answers
  initial begin
    forever begin
      @(negedge clk);
      if (busValid && rstN) begin
        cyc_t e;
        cyc_t seen;
        int lat;
        seen = '{addr: busAddr, be: busBe, wr: busWrite, wdata: busWdata};
        if (cycQ.size() == 0) begin
          check(0, "R8 unexpected bus cycle", {34'h0, busAddr}, 64'h0);
        end else begin
          e = cycQ.pop_front();
          check(busAddr == e.addr, "R2/R4 bus address", {34'h0, busAddr}, {34'h0, e.addr});
          check(busBe == e.be, "R3/R4 byte enables", {60'h0, busBe}, {60'h0, e.be});
          check(busWrite == e.wr && busIoSpace, "R2 direction and io space",
                {62'h0, busWrite, busIoSpace}, {62'h0, e.wr, 1'b1});
          if (e.wr)
            check((busWdata & laneBits(e.be)) == (e.wdata & laneBits(e.be)),
                  "R5 write lanes", {32'h0, busWdata & laneBits(e.be)},
                  {32'h0, e.wdata & laneBits(e.be)});
        end
        lat = cycNum % 3;
        cycNum++;
        for (int w = 0; w < lat; w++) begin
          @(negedge clk);
          check(busValid && busAddr == seen.addr && busBe == seen.be &&
                busWdata == seen.wdata && busWrite == seen.wr, "R7 hold while waiting",
                {busValid, busAddr, busBe}, {1'b1, seen.addr, seen.be});
        end
        for (int l = 0; l < 4; l++)
          busRdata[8*l +: 8] = busBe[l] ? mem[{busAddr[13:0], 2'(l)}] : 8'hA5;
        if (busWrite)
          for (int l = 0; l < 4; l++)
            if (busBe[l]) mem[{busAddr[13:0], 2'(l)}] = busWdata[8*l +: 8];
        busReady = 1'b1;
        @(negedge clk);
        busReady = 1'b0;
        busRdata = 32'hDEADBEEF;
      end
    end
  end

  // result monitor
  initial begin
    forever begin
      @(negedge clk);
      if (done) begin
        logic [31:0] e;
        check(!busy, "R8 not busy at done", {63'h0, busy}, 64'h0);
        if (resQ.size() == 0) begin
          check(0, "R8 unexpected done", 64'h1, 64'h0);
        end else begin
          e = resQ.pop_front();
          check(rdData == e, "R6/R10 result data", {32'h0, rdData}, {32'h0, e});
        end
        @(negedge clk);
        check(!done, "R8 done is one pulse", {63'h0, done}, 64'h0);
      end
    end
  end

  task automatic access(input logic useReg, input logic [7:0] imm, input logic [15:0] rg,
                        input logic [1:0] sz, input logic wr, input logic [31:0] wd,
                        input bit poke);
    logic [15:0] port, a;
    cyc_t c0, c1;
    bit use1;
    int n;
    logic [31:0] exp;
    port = useReg ? rg : {8'h00, imm};
    n = (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
    c0 = '{addr: {16'h0, port[15:2]}, be: 4'h0, wr: wr, wdata: 32'h0};
    c1 = '{addr: {16'h0, port[15:2] + 14'd1}, be: 4'h0, wr: wr, wdata: 32'h0};
    use1 = 0;
    exp = 32'h0;
    for (int k = 0; k < n; k++) begin
      a = port + 16'(k);
      exp[8*k +: 8] = mem[a];
      if (a[15:2] == port[15:2]) begin
        c0.be[a[1:0]] = 1'b1;
        c0.wdata[8*a[1:0] +: 8] = wd[8*k +: 8];
      end else begin
        use1 = 1;
        c1.be[a[1:0]] = 1'b1;
        c1.wdata[8*a[1:0] +: 8] = wd[8*k +: 8];
      end
    end
    cycQ.push_back(c0);
    if (use1) cycQ.push_back(c1);
    if (wr) resQ.push_back(lastRead);
    else begin
      resQ.push_back(exp);
      lastRead = exp;
    end
    @(negedge clk);
    while (busy) @(negedge clk);
    reqValid = 1; reqWrite = wr; reqUseReg = useReg; reqImm = imm;
    reqReg = rg; reqSize = sz; reqWdata = wd;
    @(negedge clk);
    reqValid = 0;
    check(busy, "R8 busy after accept", {63'h0, busy}, 64'h1);
    if (poke) begin
      // R8: a request while busy must start nothing
      reqValid = 1; reqWrite = 1; reqUseReg = 1; reqReg = 16'h5550;
      reqSize = 2'b10; reqWdata = 32'h0BADF00D;
      @(negedge clk);
      reqValid = 0;
    end
    while (!done) @(negedge clk);
    check(cycQ.size() == 0, "R4 bus cycle count", cycQ.size(), 64'h0);
  endtask

  initial begin
    for (int i = 0; i < 65536; i++) mem[i] = 8'(i * 7 + 3);
    repeat (3) @(negedge clk);
    // R9: reset state
    check(!busValid && !done && !busy && rdData == 0, "R9 reset state",
          {busValid, done, busy, rdData}, 64'h0);
    rstN = 1;
    // R1: immediate source, register value must be ignored
    access(0, 8'h07, 16'hBEEF, 2'b00, 0, 0, 0);
    access(0, 8'hFF, 16'h1234, 2'b00, 1, 32'h0000005A, 0);
    access(0, 8'hFC, 16'h0000, 2'b10, 0, 0, 0);
    // R1: register source, high address
    access(1, 8'h00, 16'hABCD, 2'b00, 0, 0, 0);
    // R3: aligned word and word at offset 1 (lanes 2,1)
    access(1, 8'h00, 16'h1234, 2'b01, 1, 32'h0000C0DE, 0);
    access(1, 8'h00, 16'h1234, 2'b01, 0, 0, 0);
    access(1, 8'h00, 16'h2001, 2'b01, 1, 32'h00003344, 0);
    access(1, 8'h00, 16'h2000, 2'b10, 0, 0, 0);
    // R4: word split at offset 3
    access(1, 8'h00, 16'h3003, 2'b01, 1, 32'h0000A1B2, 1);
    access(1, 8'h00, 16'h3003, 2'b01, 0, 0, 0);
    // R4/R5/R6: dword at offsets 1, 2, 3
    access(1, 8'h00, 16'h4001, 2'b10, 1, 32'h11223344, 0);
    access(1, 8'h00, 16'h4001, 2'b10, 0, 0, 1);
    access(1, 8'h00, 16'h4006, 2'b10, 1, 32'h55667788, 0);
    access(1, 8'h00, 16'h4006, 2'b10, 0, 0, 0);
    access(1, 8'h00, 16'h400B, 2'b11, 0, 0, 0);
    // R4: wrap at the top of the port space
    access(1, 8'h00, 16'hFFFE, 2'b10, 1, 32'hCAFEF00D, 0);
    access(1, 8'h00, 16'hFFFE, 2'b10, 0, 0, 0);
    access(0, 8'h00, 16'h7777, 2'b01, 0, 0, 0);
    access(1, 8'h00, 16'hFFFF, 2'b01, 0, 0, 0);
    // R10: write after read keeps result
    access(1, 8'h00, 16'h0101, 2'b00, 1, 32'h000000EE, 0);
    repeat (5) @(negedge clk);
    check(!busValid, "R8 idle after sequence", {63'h0, busValid}, 64'h0);
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog R8 actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule